// File: doc/BRIEF.md
# Segment Selector Privilege Checker

This block decides whether a segment load may proceed at the current privilege level. Each request carries a 16-bit selector, the privilege level of the target descriptor and a code for the kind of load. The block splits the selector into a table index, a global/local table flag and a requested privilege level. The request kind decides whether the privilege rule applies. The block also holds the current privilege level and updates it when a code segment is loaded or a gate transfer takes place.

A request is presented for one cycle with `req_valid_i` high. One cycle later the block shows the registered verdict as a single-cycle `grant_o` or `fault_o` pulse, together with the decoded index and table flag. The updated privilege level is visible in that same cycle. Descriptor storage and descriptor fetch sit outside the block; the surrounding logic supplies the descriptor privilege level.

Top module: `seg_priv_check`

## Requirements
- R1: For each accepted request, `index_o` equals selector bits 15:3, one cycle after the request.
- R2: For each accepted request, `tbl_local_o` equals selector bit 2 (0 = global table, 1 = local table), one cycle after the request.
- R3: While reset is held, and after it, `cpl_o` is 0 and `grant_o` and `fault_o` are low.
- R4: For kind codes 0 (data load), 1 (far jump) and 2 (software interrupt), the request is granted exactly when min(current level, selector bits 1:0) <= descriptor level. Otherwise it faults.
- R5: Kind code 3 (hardware exception or interrupt) is always granted, whatever the levels.
- R6: Kind code 4 (gate transfer) is always granted and sets the current level to the descriptor level.
- R7: A granted far jump sets the current level to selector bits 1:0.
- R8: Every accepted request yields exactly one one-cycle pulse on `grant_o` or on `fault_o`. Idle cycles yield neither.
- R9: A faulted request leaves the current level unchanged.
- R10: Kind codes 5 to 7 are refused with a fault.
- R11: A granted data load, software interrupt or hardware event leaves the current level unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| sel_i | input | 16 | Segment selector being loaded |
| dpl_i | input | 2 | Privilege level of the target descriptor |
| kind_i | input | 3 | Load kind code (0 data, 1 far jump, 2 software interrupt, 3 hardware event, 4 gate) |
| index_o | output | 13 | Descriptor table index of the last request |
| tbl_local_o | output | 1 | Table flag of the last request (1 = local) |
| grant_o | output | 1 | One-cycle pulse: request permitted |
| fault_o | output | 1 | One-cycle pulse: request refused |
| cpl_o | output | 2 | Current privilege level |

## Verification
All results are registered, so the verdict pulse, index, table flag and new current level for a request are due exactly one clock edge after the cycle in which that request was driven. The driver sets inputs on the falling edge and queues the expected result. It computes that result from its own model of the current level. The monitor takes one queued item just after each rising edge and compares it with the outputs then. Idle cycles queue an item that expects no pulse and an unchanged level. A missing or extra pulse therefore shows up in the cycle where it appears.

// File: rtl/seg_priv_pkg.sv
package seg_priv_pkg;
    typedef enum logic [2:0] {
        KIND_DATA   = 3'd0,
        KIND_FARJMP = 3'd1,
        KIND_SWINT  = 3'd2,
        KIND_HWEVT  = 3'd3,
        KIND_GATE   = 3'd4
    } load_kind_e;
endpackage

// File: rtl/sel_split.sv
module sel_split #(
    parameter int SEL_W = 16,
    parameter int PL_W  = 2,
    localparam int IDX_W = SEL_W - PL_W - 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [IDX_W-1:0] index_o,
    output logic             tbl_local_o,
    output logic [PL_W-1:0]  rpl_o
);
    always_comb begin
        index_o     = sel_i[SEL_W-1:PL_W+1];
        tbl_local_o = sel_i[PL_W];
        rpl_o       = sel_i[PL_W-1:0];
    end
endmodule

// File: rtl/priv_judge.sv
module priv_judge
    import seg_priv_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [2:0]      kind_i,
    input  logic [PL_W-1:0] cpl_i,
    input  logic [PL_W-1:0] rpl_i,
    input  logic [PL_W-1:0] dpl_i,
    output logic            permit_o,
    output logic            set_cpl_o,
    output logic [PL_W-1:0] cpl_new_o
);
    logic [PL_W-1:0] lowest;

    always_comb begin
        lowest    = (cpl_i < rpl_i) ? cpl_i : rpl_i;
        permit_o  = 1'b0;
        set_cpl_o = 1'b0;
        cpl_new_o = cpl_i;
        case (kind_i)
            KIND_DATA, KIND_SWINT: begin
                permit_o = (lowest <= dpl_i);
            end
            KIND_FARJMP: begin
                permit_o  = (lowest <= dpl_i);
                set_cpl_o = permit_o;
                cpl_new_o = rpl_i;
            end
            KIND_HWEVT: begin
                permit_o = 1'b1;
            end
            KIND_GATE: begin
                permit_o  = 1'b1;
                set_cpl_o = 1'b1;
                cpl_new_o = dpl_i;
            end
            default: begin
                permit_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
    import seg_priv_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int PL_W  = 2,
    localparam int IDX_W = SEL_W - PL_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [PL_W-1:0]  dpl_i,
    input  logic [2:0]       kind_i,
    output logic [IDX_W-1:0] index_o,
    output logic             tbl_local_o,
    output logic             grant_o,
    output logic             fault_o,
    output logic [PL_W-1:0]  cpl_o
);
    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             tbl_local;
        logic             grant;
        logic             fault;
        logic [PL_W-1:0]  cpl;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] idx_w;
    logic             tbl_w;
    logic [PL_W-1:0]  rpl_w;
    logic             permit_w;
    logic             set_cpl_w;
    logic [PL_W-1:0]  cpl_new_w;

    sel_split #(.SEL_W(SEL_W), .PL_W(PL_W)) i_split (
        .sel_i       (sel_i),
        .index_o     (idx_w),
        .tbl_local_o (tbl_w),
        .rpl_o       (rpl_w)
    );

    priv_judge #(.PL_W(PL_W)) i_judge (
        .kind_i    (kind_i),
        .cpl_i     (st_q.cpl),
        .rpl_i     (rpl_w),
        .dpl_i     (dpl_i),
        .permit_o  (permit_w),
        .set_cpl_o (set_cpl_w),
        .cpl_new_o (cpl_new_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.fault = 1'b0;
        if (req_valid_i) begin
            st_d.index     = idx_w;
            st_d.tbl_local = tbl_w;
            st_d.grant     = permit_w;
            st_d.fault     = !permit_w;
            if (permit_w && set_cpl_w) begin
                st_d.cpl = cpl_new_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign index_o     = st_q.index;
    assign tbl_local_o = st_q.tbl_local;
    assign grant_o     = st_q.grant;
    assign fault_o     = st_q.fault;
    assign cpl_o       = st_q.cpl;

    a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> ($countones({grant_o, fault_o}) == 1));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!grant_o && !fault_o));

    a_r9_fault_holds_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !grant_o && !fault_o) ##1 fault_o |-> $stable(cpl_o));

    a_r5_hw_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind_i == KIND_HWEVT) |=> grant_o);

    a_r6_gate_level: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind_i == KIND_GATE) |=> (grant_o && cpl_o == $past(dpl_i)));

    a_r4_rpl_within: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind_i <= KIND_SWINT && sel_i[PL_W-1:0] <= dpl_i) |=> grant_o);

    a_r1_index: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (index_o == $past(sel_i[SEL_W-1:PL_W+1])));

    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind_i > KIND_GATE) |=> fault_o);
endmodule

// File: tb/test_seg_priv_check.sv
`timescale 1ns/1ps
module test_seg_priv_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] sel = '0;
    logic [1:0]  dpl = '0;
    logic [2:0]  kind = '0;
    logic [12:0] index;
    logic        tbl_local, grant, fault;
    logic [1:0]  cpl;

    typedef struct {
        bit          chk;
        logic [12:0] idx;
        logic        tbl;
        logic        g;
        logic        f;
        logic [1:0]  cpl;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [1:0]  cpl_m = 2'd0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    seg_priv_check i_seg_priv_check (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .sel_i(sel),
        .dpl_i(dpl), .kind_i(kind), .index_o(index), .tbl_local_o(tbl_local),
        .grant_o(grant), .fault_o(fault), .cpl_o(cpl)
    );

    task automatic drive(input bit v, input logic [2:0] k, input logic [15:0] s,
                         input logic [1:0] d, input string tag);
        exp_t       e;
        logic [1:0] r, m;
        bit         ok;
        @(negedge clk);
        req_valid = v; kind = k; sel = s; dpl = d;
        r  = s[1:0];
        m  = (cpl_m < r) ? cpl_m : r;
        ok = 1'b0;
        if (v) begin
            case (k)
                3'd0, 3'd2: ok = (m <= d);
                3'd1: begin ok = (m <= d); if (ok) cpl_m = r; end
                3'd3: ok = 1'b1;
                3'd4: begin ok = 1'b1; cpl_m = d; end
                default: ok = 1'b0;
            endcase
        end
        e.chk = v; e.idx = s[15:3]; e.tbl = s[2];
        e.g = v && ok; e.f = v && !ok; e.cpl = cpl_m; e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (grant !== e.g || fault !== e.f || cpl !== e.cpl ||
                (e.chk && (index !== e.idx || tbl_local !== e.tbl))) begin
                n_bad++;
                $display("FAIL %s: got g=%0b f=%0b cpl=%0d idx=%0h tbl=%0b, want g=%0b f=%0b cpl=%0d idx=%0h tbl=%0b",
                         e.tag, grant, fault, cpl, index, tbl_local,
                         e.g, e.f, e.cpl, e.idx, e.tbl);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got hung run, want completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (cpl !== 2'd0 || grant !== 1'b0 || fault !== 1'b0) begin
            n_bad++;
            $display("FAIL R3 reset: got cpl=%0d g=%0b f=%0b, want 0 0 0", cpl, grant, fault);
        end
        rst_n = 1'b1;
        // R1 R2 decode, R4 at level 0
        drive(1, 3'd0, 16'hFFF8, 2'd0, "R1 index all ones global");
        drive(1, 3'd0, 16'h0004, 2'd0, "R2 local table");
        drive(0, 3'd0, 16'h1234, 2'd0, "R8 idle");
        // R6 gate to level 3
        drive(1, 3'd4, 16'h0010, 2'd3, "R6 gate to 3");
        drive(1, 3'd0, 16'h0023, 2'd2, "R4 data fault min 3 > 2");
        drive(1, 3'd0, 16'h0020, 2'd2, "R4 data grant rpl 0");
        drive(1, 3'd2, 16'h0033, 2'd1, "R4 swint fault");
        drive(1, 3'd2, 16'h0031, 2'd1, "R11 swint grant keeps level");
        drive(1, 3'd3, 16'h0043, 2'd0, "R5 hw event granted");
        drive(1, 3'd1, 16'h0053, 2'd0, "R9 far jump fault keeps level");
        drive(1, 3'd1, 16'h0051, 2'd1, "R7 far jump sets level 1");
        drive(1, 3'd5, 16'h0060, 2'd3, "R10 code 5 refused");
        drive(1, 3'd7, 16'h0060, 2'd3, "R10 code 7 refused");
        drive(1, 3'd4, 16'h0078, 2'd0, "R6 gate to 0");
        drive(0, 3'd4, 16'h0000, 2'd3, "R8 idle no gate");
        // R4 full sweep of levels
        for (int c = 0; c < 4; c++) begin
            drive(1, 3'd4, 16'h0100, c[1:0], "R6 sweep gate");
            for (int r = 0; r < 4; r++) begin
                for (int d = 0; d < 4; d++) begin
                    drive(1, 3'd0, {13'(c * 16 + r * 4 + d), 1'b1, r[1:0]}, d[1:0], "R4 sweep data");
                end
            end
        end
        drive(1, 3'd1, 16'hABCB, 2'd3, "R7 far jump to 3");
        drive(0, 3'd0, 16'h0000, 2'd0, "R8 final idle");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule